// File: doc/BRIEF.md
# Binary to Signed-Digit Quaternary Converter

The block takes a W-bit two's complement integer and turns it into a word of quaternary signed digits. Each digit lies between -3 and +3 and is held as a 3-bit two's complement field. Every digit carries the sign of the input, so a positive input gives digits that are all zero or positive, and a negative input gives digits that are all zero or negative. The digits are the remainders of repeated division of the input's magnitude by four. Because four is a power of two, the division needs no arithmetic: the magnitude is cut into 2-bit groups, and each group is negated when the input was negative.

A word enters through a valid/ready handshake. It then leaves as a stream of digits, one per handshake beat, with the least significant digit first. The stream stops at the last digit that carries weight, which matches the point where the quotient reaches zero. The final beat raises a completion flag. While the stream is being sent, the whole digit word is also shown in parallel. The digit count NDIG is derived from W as ceil((W+1)/2). Digit positions above the highest significant digit read as zero.

Top module: `qsd_conv`

## Requirements
- R1: Every digit field on dig_o and in word_o is a 3-bit two's complement value in -3..+3. The code 3'b100 never appears.
- R2: For input x, digit i of word_o (bits 3i+2..3i) equals sign(x) * ((|x| >> 2i) mod 4). The sum of digit i times 4^i over all digits equals x.
- R3: A non-negative input yields no negative digit, and a negative input yields no positive digit. The word for -x is the digit-wise negation of the word for x.
- R4: An input of zero yields an all-zero word_o, sent as a single beat with dig_last_o high and dig_idx_o = 0.
- R5: Digits are sent least significant first. Beat k carries dig_idx_o = k and dig_o equal to digit k of word_o.
- R6: The number of beats is the index of the highest nonzero digit plus one, with a minimum of one. dig_last_o is high on the final beat only. Every digit above the final index is zero.
- R7: in_ready_o falls in the cycle after an input is accepted. It stays low until the final beat has been taken, and it is high again in the next cycle. in_valid_i asserted while in_ready_o is low has no effect on word_o or on the digit stream.
- R8: While dig_valid_o is high and dig_ready_i is low, dig_valid_o, dig_o, dig_idx_o and word_o hold their values.
- R9: After reset, in_ready_o is high and dig_valid_o is low.
- R10: The full input range is handled, including the most negative value. For W = 8, -128 yields digits 0,0,0,-2,0 and four beats, and 127 yields 3,3,3,1,0 and four beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Converter idle and able to accept an input |
| in_data_i | input | W | Two's complement input integer |
| dig_valid_o | output | 1 | Digit beat valid |
| dig_ready_i | input | 1 | Consumer takes the current digit |
| dig_o | output | 3 | Current signed digit, two's complement |
| dig_idx_o | output | CNT_W | Position of the current digit, 0 = least significant |
| dig_last_o | output | 1 | Final beat of the word (word complete) |
| word_o | output | 3*NDIG | Full digit word, digit i at bits 3i+2..3i |

## Verification
The bench sweeps every 8-bit input twice. In the second pass it stalls each beat and drives a new input while the converter is busy. The most negative input is the sharpest case. A design that negated into W-1 bits, or that treated the top group as signed, would lose the -2 in digit 3. Values with zero groups inside them, such as 64 or -16, show whether the stream stops at the highest nonzero digit rather than at the first zero digit. Zero shows whether the stream still sends exactly one final beat instead of none or NDIG. Stalled beats and inputs offered while busy expose a converter that moves its index under backpressure or recaptures its word too early.

// File: rtl/qsd_pkg.sv
package qsd_pkg;
  localparam int DIG_W = 3;

  function automatic logic [DIG_W-1:0] grp_to_dig(input logic [1:0] grp, input logic neg);
    logic [DIG_W-1:0] pos;
    pos = {1'b0, grp};
    return neg ? (DIG_W'(0) - pos) : pos;
  endfunction
endpackage

// File: rtl/qsd_split.sv
module qsd_split
  import qsd_pkg::*;
#(
  parameter int W    = 8,
  parameter int NDIG = 5
) (
  input  logic [W-1:0]            data_i,
  output logic [NDIG*DIG_W-1:0]   word_o
);
  localparam int MAG_W = 2 * NDIG;

  logic             neg;
  logic [MAG_W-1:0] mag;

  always_comb begin
    neg = data_i[W-1];
    mag = '0;
    // unsigned W-bit result keeps 2^(W-1) exact for the most negative input
    mag[W-1:0] = neg ? (~data_i + W'(1)) : data_i;
  end

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    assign word_o[g*DIG_W +: DIG_W] = grp_to_dig(mag[2*g +: 2], neg);
  end
endmodule

// File: rtl/qsd_len.sv
module qsd_len
  import qsd_pkg::*;
#(
  parameter int NDIG  = 5,
  parameter int CNT_W = 3
) (
  input  logic [NDIG*DIG_W-1:0] word_i,
  output logic [CNT_W-1:0]      len_o
);
  // highest nonzero digit wins; zero word still sends one beat
  always_comb begin
    len_o = CNT_W'(1);
    for (int i = 0; i < NDIG; i++) begin
      if (word_i[i*DIG_W +: DIG_W] != '0) len_o = CNT_W'(i + 1);
    end
  end
endmodule

// File: rtl/qsd_seq.sv
module qsd_seq
  import qsd_pkg::*;
#(
  parameter int NDIG  = 5,
  parameter int CNT_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  input  logic [NDIG*DIG_W-1:0]  word_i,
  input  logic [CNT_W-1:0]       len_i,
  output logic                   dig_valid_o,
  input  logic                   dig_ready_i,
  output logic [DIG_W-1:0]       dig_o,
  output logic [CNT_W-1:0]       dig_idx_o,
  output logic                   dig_last_o,
  output logic [NDIG*DIG_W-1:0]  word_o
);
  logic                            busy_q;
  logic [CNT_W-1:0]                idx_q, len_q;
  logic [NDIG-1:0][DIG_W-1:0]      word_q;
  logic                            accept, fire, last;

  assign accept = in_valid_i && !busy_q;
  assign last   = busy_q && (idx_q == len_q - CNT_W'(1));
  assign fire   = busy_q && dig_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      len_q  <= '0;
      word_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      len_q  <= len_i;
      word_q <= word_i;
    end else if (fire) begin
      if (last) busy_q <= 1'b0;
      else      idx_q  <= idx_q + CNT_W'(1);
    end
  end

  always_comb begin
    dig_o = '0;
    for (int i = 0; i < NDIG; i++) begin
      if (idx_q == CNT_W'(i)) dig_o = word_q[i];
    end
  end

  assign in_ready_o  = !busy_q;
  assign dig_valid_o = busy_q;
  assign dig_idx_o   = idx_q;
  assign dig_last_o  = last;
  assign word_o      = word_q;

  // checker-side views of the held word
  logic any_pos, any_neg, hi_nz;
  always_comb begin
    any_pos = 1'b0;
    any_neg = 1'b0;
    hi_nz   = 1'b0;
    for (int i = 0; i < NDIG; i++) begin
      if (word_q[i][DIG_W-1]) any_neg = 1'b1;
      else if (word_q[i] != '0) any_pos = 1'b1;
      if (CNT_W'(i) > idx_q && word_q[i] != '0) hi_nz = 1'b1;
    end
  end

  // R1
  dig_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dig_valid_o |-> dig_o != 3'b100);

  // R3
  sign_uniform_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dig_valid_o |-> !(any_pos && any_neg));

  // R6
  hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dig_valid_o && dig_last_o) |-> !hi_nz);

  // R5
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dig_valid_o && dig_ready_i && !dig_last_o) |=>
      (dig_valid_o && dig_idx_o == $past(dig_idx_o) + CNT_W'(1)));

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dig_valid_o && !dig_ready_i) |=>
      (dig_valid_o && $stable(dig_o) && $stable(dig_idx_o) && $stable(word_o)));

  // R7
  done_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dig_valid_o && dig_ready_i && dig_last_o) |=> (in_ready_o && !dig_valid_o));

  // R7
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (!in_ready_o && dig_valid_o && dig_idx_o == '0));
endmodule

// File: rtl/qsd_conv.sv
module qsd_conv
  import qsd_pkg::*;
#(
  parameter  int W     = 8,
  localparam int NDIG  = (W + 2) / 2,
  localparam int CNT_W = $clog2(NDIG + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  input  logic [W-1:0]          in_data_i,
  output logic                  dig_valid_o,
  input  logic                  dig_ready_i,
  output logic [2:0]            dig_o,
  output logic [CNT_W-1:0]      dig_idx_o,
  output logic                  dig_last_o,
  output logic [NDIG*3-1:0]     word_o
);
  logic [NDIG*DIG_W-1:0] word_d;
  logic [CNT_W-1:0]      len_d;

  qsd_split #(.W(W), .NDIG(NDIG)) u_split (
    .data_i (in_data_i),
    .word_o (word_d)
  );

  qsd_len #(.NDIG(NDIG), .CNT_W(CNT_W)) u_len (
    .word_i (word_d),
    .len_o  (len_d)
  );

  qsd_seq #(.NDIG(NDIG), .CNT_W(CNT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .word_i      (word_d),
    .len_i       (len_d),
    .dig_valid_o (dig_valid_o),
    .dig_ready_i (dig_ready_i),
    .dig_o       (dig_o),
    .dig_idx_o   (dig_idx_o),
    .dig_last_o  (dig_last_o),
    .word_o      (word_o)
  );

  // R4
  zero_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_data_i == '0) |=>
      (dig_valid_o && dig_last_o && word_o == '0));
endmodule

// File: tb/qsd_conv_bench.sv
module qsd_conv_bench;
  localparam int W     = 8;
  localparam int NDIG  = (W + 2) / 2;
  localparam int CNT_W = $clog2(NDIG + 1);

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic [W-1:0]         in_data = '0;
  logic                 dig_valid;
  logic                 dig_ready = 1'b0;
  logic [2:0]           dig;
  logic [CNT_W-1:0]     dig_idx;
  logic                 dig_last;
  logic [NDIG*3-1:0]    word;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  qsd_conv #(.W(W)) u_qsd_conv (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_data_i   (in_data),
    .dig_valid_o (dig_valid),
    .dig_ready_i (dig_ready),
    .dig_o       (dig),
    .dig_idx_o   (dig_idx),
    .dig_last_o  (dig_last),
    .word_o      (word)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_dig(input int v, input int i);
    int m, d;
    m = (v < 0) ? -v : v;
    d = (m >> (2 * i)) & 3;
    return (v < 0) ? -d : d;
  endfunction

  function automatic int exp_len(input int v);
    int l;
    l = 1;
    for (int i = 0; i < NDIG; i++) if (exp_dig(v, i) != 0) l = i + 1;
    return l;
  endfunction

  function automatic logic [NDIG*3-1:0] exp_word(input int v);
    logic [NDIG*3-1:0] w;
    int d;
    for (int i = 0; i < NDIG; i++) begin
      d = exp_dig(v, i);
      w[3*i +: 3] = d[2:0];
    end
    return w;
  endfunction

  function automatic int word_value(input logic [NDIG*3-1:0] w);
    int s, p;
    s = 0;
    p = 1;
    for (int i = 0; i < NDIG; i++) begin
      s += int'($signed(w[3*i +: 3])) * p;
      p *= 4;
    end
    return s;
  endfunction

  function automatic bit sign_ok(input int v, input logic [NDIG*3-1:0] w);
    for (int i = 0; i < NDIG; i++) begin
      if (v >= 0 && w[3*i+2]) return 1'b0;
      if (v < 0 && !w[3*i+2] && w[3*i +: 3] != 3'b000) return 1'b0;
      if (w[3*i +: 3] == 3'b100) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic run(input int v, input bit st);
    int n;
    logic [NDIG*3-1:0] ew;
    n  = exp_len(v);
    ew = exp_word(v);
    @(negedge clk);
    chk(in_ready == 1'b1, "R7 ready when idle", int'(in_ready), 1);
    in_data  = v[W-1:0];
    in_valid = 1'b1;
    @(negedge clk);
    if (st) in_data = ~v[W-1:0];
    else    in_valid = 1'b0;
    chk(word_value(word) == v, "R2 word value", word_value(word), v);
    chk(sign_ok(v, word), "R1 R3 digit sign/range", int'(word), int'(ew));
    for (int b = 0; b < n; b++) begin
      chk(dig_valid == 1'b1, "R6 beat valid", int'(dig_valid), 1);
      chk(in_ready == 1'b0, "R7 ready low while busy", int'(in_ready), 0);
      chk(word == ew, "R2 word digits", int'(word), int'(ew));
      chk(dig_idx == CNT_W'(b), "R5 digit index", int'(dig_idx), b);
      chk(int'($signed(dig)) == exp_dig(v, b), "R5 digit value", int'($signed(dig)), exp_dig(v, b));
      chk(dig_last == (b == n - 1), "R6 last flag", int'(dig_last), int'(b == n - 1));
      if (st) begin
        @(negedge clk);
        chk(dig_valid && dig_idx == CNT_W'(b) && int'($signed(dig)) == exp_dig(v, b),
            "R8 stall hold", int'(dig_idx), b);
        chk(word == ew, "R7 input ignored while busy", int'(word), int'(ew));
        if (b == n - 1) in_valid = 1'b0;
      end
      dig_ready = 1'b1;
      @(negedge clk);
      dig_ready = 1'b0;
    end
    in_valid = 1'b0;
    chk(dig_valid == 1'b0, "R6 no beat after last", int'(dig_valid), 0);
    chk(in_ready == 1'b1, "R7 ready after last", int'(in_ready), 1);
  endtask

  initial begin
    #(10 * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9
    chk(in_ready == 1'b1, "R9 reset in_ready", int'(in_ready), 1);
    chk(dig_valid == 1'b0, "R9 reset dig_valid", int'(dig_valid), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R4 zero input: one beat, all-zero word
    run(0, 1'b0);
    // R10 extremes
    chk(exp_len(-128) == 4 && exp_dig(-128, 3) == -2, "R10 model -128", exp_len(-128), 4);
    run(-128, 1'b0);
    run(127, 1'b0);
    // R3 digit-wise negation pair
    run(57, 1'b0);
    run(-57, 1'b0);

    for (int v = -(1 << (W - 1)); v < (1 << (W - 1)); v++) run(v, 1'b0);
    for (int v = -(1 << (W - 1)); v < (1 << (W - 1)); v++) run(v, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule